// File: doc/BRIEF.md
# Multicycle RISC Datapath Core

This block is the register-level datapath of a 32-bit load/store processor in which each instruction spends three to five clock cycles. One ALU and one memory port serve every step; values that must survive from one step to the next sit in internal latches: the program counter, the instruction latch, two operand latches (A and B), the ALU result latch and the memory data latch. A 32-entry register file, a sign extender, a shift-by-two unit and the two ALU input selectors complete it.

A separate controller sequences the block. In each cycle it drives six small control codes: operand selects, ALU mode, memory action, register-file action and PC update. It reads back the latched instruction word and the ALU zero flag. The memory is one shared instruction/data array. The block presents an address, read and write strobes and write data. Read data returns within the same cycle, and a write takes effect at the clock edge. The usual flow is: fetch (IR from memory at PC, PC advanced by 4), decode (operand latches loaded, branch target pre-computed into the ALU result latch), then execute, memory and write-back steps chosen by the controller.

Top module: `mc_datapath`

## Requirements
- R1: While rst_n is low at a clock edge, PC becomes RESET_PC (default 0), and the instruction, operand, ALU-result and memory-data latches and all registers become 0.
- R2: With ctl_mem = 1 (fetch), mem_addr equals PC, mem_re is 1, and the instruction latch (output instr) takes mem_rdata at the edge. With any other ctl_mem code the instruction latch holds.
- R3: ctl_src_a selects the first ALU operand: 0 for PC, 1 for A. ctl_src_b selects the second: 0 for B, 1 for the constant 4, 2 for the sign-extended instr[15:0], 3 for that value shifted left by 2.
- R4: ctl_alu_op selects the ALU mode: 0 and 3 add, 1 subtracts (first minus second). Code 2 decodes instr[5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than giving 1 or 0; any other value adds. alu_zero is 1 exactly when the ALU result is 0. The ALU result latch loads the ALU result on every clock edge.
- R5: With ctl_reg = 1, A loads register[instr[25:21]] and B loads register[instr[20:16]] at the edge. With any other code A and B hold.
- R6: ctl_reg = 2 writes the ALU result latch into register[instr[15:11]]. ctl_reg = 3 writes the memory data latch into register[instr[20:16]]. Both writes take effect at the edge.
- R7: Register 0 always reads as 0, and writes to it are ignored.
- R8: ctl_mem = 2 drives mem_addr from the ALU result latch with mem_re = 1, and the memory data latch takes mem_rdata at the edge. ctl_mem = 3 drives mem_we = 1, with mem_addr from the ALU result latch and mem_wdata from B.
- R9: ctl_pc = 1 loads PC with the ALU result. ctl_pc = 0 holds PC.
- R10: ctl_pc = 2 loads PC from the ALU result latch only when alu_zero is 1 in that cycle; otherwise PC holds.
- R11: ctl_pc = 3 loads PC with {PC[31:28], instr[25:0], 2'b00}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_src_a | input | 1 | First ALU operand select |
| ctl_src_b | input | 2 | Second ALU operand select |
| ctl_alu_op | input | 2 | ALU mode |
| ctl_mem | input | 2 | Memory action: idle, fetch, load, store |
| ctl_reg | input | 2 | Register action: idle, read operands, write ALU result, write memory data |
| ctl_pc | input | 2 | PC update: hold, ALU, conditional, jump |
| mem_addr | output | 32 | Memory byte address |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| mem_wdata | output | 32 | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| instr | output | 32 | Latched instruction word for the controller |
| alu_zero | output | 1 | ALU result equals zero |

## Verification
The assertions check every cycle that the PC holds, follows the ALU or follows the ALU result latch exactly as its update code and the zero flag allow. They also check that the instruction latch changes only on a fetch, that subtraction is consistent, and that a register write reads back at its address. Register 0 is checked to stay zero. Only the bench's scenarios can show the arithmetic results of every function-field operation over a grid of operand values, and the operand-select variants. The same holds for complete load and store round trips through memory, taken and untaken branches with forward and backward offsets, and the jump target formed from the upper PC bits.

// File: rtl/mc_dp_pkg.sv
// Package: shared widths and control encodings of the multicycle datapath.
// Assumes a fixed 32-bit instruction format with 5-bit register fields.
package mc_dp_pkg;
    localparam int XLEN    = 32;
    localparam int REG_AW  = 5;
    localparam int NREGS   = 1 << REG_AW;
    localparam int IMM_W   = 16;
    localparam int FUNCT_W = 6;
    localparam int JIDX_W  = 26;
    localparam int PCHI_W  = XLEN - JIDX_W - 2;

    typedef enum logic [0:0] {SRCA_PC = 1'b0, SRCA_REG = 1'b1} src_a_e;
    typedef enum logic [1:0] {SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_IMM_X4} src_b_e;
    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_FUNCT, ALU_ADD_ALT} alu_sel_e;
    typedef enum logic [1:0] {MEM_IDLE, MEM_FETCH, MEM_LOAD, MEM_STORE} mem_op_e;
    typedef enum logic [1:0] {REG_IDLE, REG_READ, REG_WR_ALU, REG_WR_MDR} reg_op_e;
    typedef enum logic [1:0] {PC_HOLD, PC_ALU, PC_BRANCH, PC_JUMP} pc_op_e;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/mc_regfile.sv
// Register file: NREGS words, two combinational read ports, one write port
// taking effect at the clock edge. Entry 0 is a constant zero.
// Assumes the caller never needs a read-during-write bypass.
module mc_regfile
    import mc_dp_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int W  = XLEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);
    localparam int N = 1 << AW;

    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        if (i == 0) begin : g_zero
            // Purpose: entry 0 is tied to zero and never written.
            always_ff @(posedge clk) begin
                regs[i] <= '0;
            end
        end else begin : g_word
            // Purpose: clear on reset, load on an addressed write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[i] <= '0;
                end else if (we && waddr == AW'(i)) begin
                    regs[i] <= wdata;
                end
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    AST_RF_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> (raddr_a != $past(waddr)) || (rdata_a == $past(wdata))); // R6
    AST_RF_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0) |=> (raddr_b != '0) || (rdata_b == '0)); // R7
endmodule

// File: rtl/mc_operand_sel.sv
// Operand selection: sign-extends the immediate, forms its word-shifted copy
// and picks both ALU operands. Purely combinational.
module mc_operand_sel
    import mc_dp_pkg::*;
(
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  a_val,
    input  logic [XLEN-1:0]  b_val,
    input  logic [IMM_W-1:0] imm,
    input  src_a_e           src_a,
    input  src_b_e           src_b,
    output logic [XLEN-1:0]  op_a,
    output logic [XLEN-1:0]  op_b
);
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] imm_x4;

    assign imm_sx = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign imm_x4 = {imm_sx[XLEN-3:0], 2'b00};

    // Purpose: first operand is the PC or the A latch.
    always_comb begin
        op_a = (src_a == SRCA_PC) ? pc : a_val;
    end

    // Purpose: second operand is B, four, the immediate or the word offset.
    always_comb begin
        unique case (src_b)
            SRCB_REG:    op_b = b_val;
            SRCB_FOUR:   op_b = XLEN'(4);
            SRCB_IMM:    op_b = imm_sx;
            default:     op_b = imm_x4;
        endcase
    end
endmodule

// File: rtl/mc_alu.sv
// ALU: add, subtract, or an operation decoded from the function field.
// Unknown function codes add. Combinational; zero flag on the result.
module mc_alu
    import mc_dp_pkg::*;
(
    input  logic [XLEN-1:0]    op_a,
    input  logic [XLEN-1:0]    op_b,
    input  alu_sel_e           sel,
    input  logic [FUNCT_W-1:0] funct,
    output logic [XLEN-1:0]    y,
    output logic               zero
);
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] diff;
    logic            lt_signed;

    assign sum       = op_a + op_b;
    assign diff      = op_a - op_b;
    assign lt_signed = $signed(op_a) < $signed(op_b);

    // Purpose: choose the result by mode and, in function mode, by funct.
    always_comb begin
        y = sum;
        if (sel == ALU_SUB) begin
            y = diff;
        end else if (sel == ALU_FUNCT) begin
            case (funct)
                FN_SUB:  y = diff;
                FN_AND:  y = op_a & op_b;
                FN_OR:   y = op_a | op_b;
                FN_SLT:  y = XLEN'(lt_signed);
                default: y = sum;
            endcase
        end
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mc_datapath.sv
// Multicycle datapath top: PC, instruction, operand, ALU-result and memory
// data latches around one ALU and one memory port. Control codes come from an
// external sequencer each cycle; memory read data is valid in the same cycle.
module mc_datapath
    import mc_dp_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_src_a,
    input  logic [1:0]  ctl_src_b,
    input  logic [1:0]  ctl_alu_op,
    input  logic [1:0]  ctl_mem,
    input  logic [1:0]  ctl_reg,
    input  logic [1:0]  ctl_pc,
    output logic [31:0] mem_addr,
    input  logic [31:0] mem_rdata,
    output logic [31:0] mem_wdata,
    output logic        mem_re,
    output logic        mem_we,
    output logic [31:0] instr,
    output logic        alu_zero
);
    src_a_e   src_a;
    src_b_e   src_b;
    alu_sel_e alu_sel;
    mem_op_e  mem_op;
    reg_op_e  reg_op;
    pc_op_e   pc_op;

    assign src_a   = src_a_e'(ctl_src_a);
    assign src_b   = src_b_e'(ctl_src_b);
    assign alu_sel = alu_sel_e'(ctl_alu_op);
    assign mem_op  = mem_op_e'(ctl_mem);
    assign reg_op  = reg_op_e'(ctl_reg);
    assign pc_op   = pc_op_e'(ctl_pc);

    logic [XLEN-1:0]   pc_q, ir_q, a_q, b_q, alu_out_q, mdr_q;
    logic [XLEN-1:0]   rf_a, rf_b, op_a, op_b, alu_y, jump_tgt;
    logic              alu_z;
    logic              rf_we;
    logic [REG_AW-1:0] rf_waddr;
    logic [XLEN-1:0]   rf_wdata;

    assign rf_we    = (reg_op == REG_WR_ALU) || (reg_op == REG_WR_MDR);
    assign rf_waddr = (reg_op == REG_WR_ALU) ? ir_q[15:11] : ir_q[20:16];
    assign rf_wdata = (reg_op == REG_WR_ALU) ? alu_out_q : mdr_q;

    mc_regfile #(.AW(REG_AW), .W(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (ir_q[25:21]),
        .raddr_b (ir_q[20:16]),
        .rdata_a (rf_a),
        .rdata_b (rf_b),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata)
    );

    mc_operand_sel u_opsel (
        .pc    (pc_q),
        .a_val (a_q),
        .b_val (b_q),
        .imm   (ir_q[IMM_W-1:0]),
        .src_a (src_a),
        .src_b (src_b),
        .op_a  (op_a),
        .op_b  (op_b)
    );

    mc_alu u_alu (
        .op_a  (op_a),
        .op_b  (op_b),
        .sel   (alu_sel),
        .funct (ir_q[FUNCT_W-1:0]),
        .y     (alu_y),
        .zero  (alu_z)
    );

    assign jump_tgt = {pc_q[XLEN-1 -: PCHI_W], ir_q[JIDX_W-1:0], 2'b00};

    // Purpose: program counter update by the controller's PC code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else begin
            case (pc_op)
                PC_ALU:    pc_q <= alu_y;
                PC_BRANCH: if (alu_z) pc_q <= alu_out_q;
                PC_JUMP:   pc_q <= jump_tgt;
                default:   pc_q <= pc_q;
            endcase
        end
    end

    // Purpose: instruction and memory-data latches capture the read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            mdr_q <= '0;
        end else begin
            if (mem_op == MEM_FETCH) ir_q  <= mem_rdata;
            if (mem_op == MEM_LOAD)  mdr_q <= mem_rdata;
        end
    end

    // Purpose: operand latches load from the register file on a read step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (reg_op == REG_READ) begin
            a_q <= rf_a;
            b_q <= rf_b;
        end
    end

    // Purpose: ALU result latch follows the ALU every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) alu_out_q <= '0;
        else        alu_out_q <= alu_y;
    end

    assign mem_addr  = (mem_op == MEM_FETCH) ? pc_q : alu_out_q;
    assign mem_re    = (mem_op == MEM_FETCH) || (mem_op == MEM_LOAD);
    assign mem_we    = (mem_op == MEM_STORE);
    assign mem_wdata = b_q;
    assign instr     = ir_q;
    assign alu_zero  = alu_z;

    AST_PC_FOLLOWS_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == PC_ALU) |=> (pc_q == $past(alu_y))); // R9
    AST_PC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == PC_HOLD) |=> $stable(pc_q)); // R9
    AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == PC_BRANCH && !alu_z) |=> $stable(pc_q)); // R10
    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == PC_BRANCH && alu_z) |=> (pc_q == $past(alu_out_q))); // R10
    AST_IR_ONLY_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_op != MEM_FETCH) |=> $stable(ir_q)); // R2
    AST_SUB_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_sel == ALU_SUB) |-> ((alu_y + op_b) == op_a)); // R4
    AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_op != REG_READ) |=> ($stable(a_q) && $stable(b_q))); // R5
endmodule

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;
    import mc_dp_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        ctl_src_a = 1'b0;
    logic [1:0]  ctl_src_b = '0, ctl_alu_op = '0, ctl_mem = '0, ctl_reg = '0, ctl_pc = '0;
    logic [31:0] mem_addr, mem_rdata, mem_wdata, instr;
    logic        mem_re, mem_we, alu_zero;

    mc_datapath u_mc_datapath (
        .clk(clk), .rst_n(rst_n),
        .ctl_src_a(ctl_src_a), .ctl_src_b(ctl_src_b), .ctl_alu_op(ctl_alu_op),
        .ctl_mem(ctl_mem), .ctl_reg(ctl_reg), .ctl_pc(ctl_pc),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_we(mem_we), .instr(instr), .alu_zero(alu_zero)
    );

    logic [31:0] ram [4096];
    assign mem_rdata = ram[mem_addr[13:2]];
    always @(posedge clk) if (mem_we) ram[mem_addr[13:2]] <= mem_wdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] exp_pc;
    logic [31:0] shadow [32];

    localparam logic [15:0] DATA_BASE = 16'h3000;
    localparam logic [15:0] DUMP_ADDR = 16'h3F00;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic sa, input logic [1:0] sb, input logic [1:0] op,
                        input logic [1:0] mo, input logic [1:0] ro, input logic [1:0] po);
        ctl_src_a = sa; ctl_src_b = sb; ctl_alu_op = op;
        ctl_mem = mo; ctl_reg = ro; ctl_pc = po;
        @(posedge clk); #1;
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] ref_fn(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        case (f)
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    // Fetch and decode, checking the fetch address (R2) and the latched word.
    task automatic fetch_decode(input logic [31:0] word);
        ram[exp_pc[13:2]] = word;
        ctl_src_a = SRCA_PC; ctl_src_b = SRCB_FOUR; ctl_alu_op = ALU_ADD;
        ctl_mem = MEM_FETCH; ctl_reg = REG_IDLE; ctl_pc = PC_ALU;
        #1;
        check("R2 fetch address", mem_addr, exp_pc);
        check("R2 fetch read strobe", {31'd0, mem_re}, 32'd1);
        @(posedge clk); #1;
        check("R2 instruction latch", instr, word);
        exp_pc = exp_pc + 32'd4;
        step(SRCA_PC, SRCB_IMM_X4, ALU_ADD, MEM_IDLE, REG_READ, PC_HOLD);
    endtask

    task automatic do_lw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm);
        fetch_decode({6'h23, rs, rt, imm});
        step(SRCA_REG, SRCB_IMM, ALU_ADD, MEM_IDLE, REG_IDLE, PC_HOLD);
        step(SRCA_REG, SRCB_IMM, ALU_ADD, MEM_LOAD, REG_IDLE, PC_HOLD);
        step(SRCA_REG, SRCB_IMM, ALU_ADD, MEM_IDLE, REG_WR_MDR, PC_HOLD);
        if (rt != 0) shadow[rt] = ram[(shadow[rs] + sx(imm)) >> 2 & 32'hFFF];
    endtask

    task automatic do_sw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm);
        fetch_decode({6'h2B, rs, rt, imm});
        step(SRCA_REG, SRCB_IMM, ALU_ADD, MEM_IDLE, REG_IDLE, PC_HOLD);
        ctl_mem = MEM_STORE; #1;
        check("R8 store strobe", {31'd0, mem_we}, 32'd1);
        check("R8 store address", mem_addr, shadow[rs] + sx(imm));
        @(posedge clk); #1;
    endtask

    // Store a register to the dump slot and compare with the expected value.
    task automatic dump_check(input logic [4:0] r, input string req);
        ram[DUMP_ADDR >> 2] = 32'hDEAD_BEEF;
        do_sw(r, 5'd0, DUMP_ADDR);
        check(req, ram[DUMP_ADDR >> 2], shadow[r]);
    endtask

    task automatic do_r(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd, input logic [5:0] f);
        fetch_decode({6'h00, rs, rt, rd, 5'd0, f});
        step(SRCA_REG, SRCB_REG, ALU_FUNCT, MEM_IDLE, REG_IDLE, PC_HOLD);
        step(SRCA_REG, SRCB_REG, ALU_FUNCT, MEM_IDLE, REG_WR_ALU, PC_HOLD);
        if (rd != 0) shadow[rd] = ref_fn(f, shadow[rs], shadow[rt]);
    endtask

    // Immediate-style arithmetic: first operand chosen by sa, second by sb.
    task automatic do_imm(input logic sa, input logic [1:0] sb, input logic [1:0] op,
                          input logic [4:0] rs, input logic [15:0] imm);
        logic [31:0] a, b, r;
        logic [4:0]  rd;
        rd = imm[15:11];
        fetch_decode({6'h08, rs, 5'd0, imm});
        a = sa ? shadow[rs] : exp_pc;
        case (sb)
            2'd0:    b = shadow[0];
            2'd1:    b = 32'd4;
            2'd2:    b = sx(imm);
            default: b = {sx(imm)[29:0], 2'b00};
        endcase
        r = (op == ALU_SUB) ? a - b : a + b;
        step(sa, sb, op, MEM_IDLE, REG_IDLE, PC_HOLD);
        step(sa, sb, op, MEM_IDLE, REG_WR_ALU, PC_HOLD);
        if (rd != 0) shadow[rd] = r;
    endtask

    task automatic do_beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
        logic [31:0] tgt;
        fetch_decode({6'h04, rs, rt, imm});
        tgt = exp_pc + {sx(imm)[29:0], 2'b00};
        ctl_src_a = SRCA_REG; ctl_src_b = SRCB_REG; ctl_alu_op = ALU_SUB;
        ctl_mem = MEM_IDLE; ctl_reg = REG_IDLE; ctl_pc = PC_BRANCH;
        #1;
        check("R4 zero flag on compare", {31'd0, alu_zero}, {31'd0, shadow[rs] == shadow[rt]});
        @(posedge clk); #1;
        if (shadow[rs] == shadow[rt]) exp_pc = tgt;
    endtask

    task automatic do_jump(input logic [25:0] idx);
        fetch_decode({6'h02, idx});
        step(SRCA_PC, SRCB_FOUR, ALU_ADD, MEM_IDLE, REG_IDLE, PC_JUMP);
        exp_pc = {exp_pc[31:28], idx, 2'b00};
    endtask

    logic [31:0] vals [6];
    logic [5:0]  fns  [6];

    initial begin
        for (int i = 0; i < 4096; i++) ram[i] = '0;
        for (int i = 0; i < 32; i++) shadow[i] = '0;
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h1234_5678;
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A; fns[5] = 6'h07;
        for (int i = 0; i < 6; i++) ram[(DATA_BASE >> 2) + i] = vals[i];

        // R1: reset state
        ctl_mem = MEM_IDLE;
        repeat (3) @(posedge clk);
        #1;
        check("R1 instruction latch reset", instr, 32'd0);
        rst_n = 1'b1;
        exp_pc = 32'd0;
        dump_check(5'd7, "R1 register cleared by reset");

        // R6/R8: load operands into r1..r6 through memory data latch
        for (int i = 0; i < 6; i++) do_lw(5'(i + 1), 5'd0, DATA_BASE + 16'(4 * i));
        for (int i = 0; i < 6; i++) dump_check(5'(i + 1), "R8 load then R6 write-back");

        // R4/R6: function-field sweep over all operand pairs
        for (int i = 1; i <= 6; i++)
            for (int j = 1; j <= 6; j++)
                for (int k = 0; k < 6; k++) begin
                    do_r(5'(i), 5'(j), 5'd10, fns[k]);
                    dump_check(5'd10, "R4 function result");
                end

        // R7: writes to register 0 are ignored
        do_r(5'd6, 5'd2, 5'd0, 6'h20);
        dump_check(5'd0, "R7 r0 after ALU write");
        do_lw(5'd0, 5'd0, DATA_BASE + 16'd20);
        dump_check(5'd0, "R7 r0 after memory write");

        // R3/R4: operand selects and plain add/subtract modes
        do_imm(SRCA_REG, SRCB_IMM, ALU_ADD, 5'd6, 16'hF8FF);
        dump_check(5'd31, "R3 sign-extended immediate");
        do_imm(SRCA_REG, SRCB_IMM_X4, ALU_ADD_ALT, 5'd6, 16'h9003);
        dump_check(5'd18, "R3 shifted immediate with mode 3");
        do_imm(SRCA_PC, SRCB_FOUR, ALU_SUB, 5'd0, 16'h2800);
        dump_check(5'd5, "R3 PC operand minus four");
        do_imm(SRCA_REG, SRCB_REG, ALU_SUB, 5'd1, 16'h6000);
        dump_check(5'd12, "R3 B operand via subtract");

        // R10: taken forward, untaken, taken backward
        do_beq(5'd2, 5'd2, 16'h0010);
        do_r(5'd2, 5'd2, 5'd11, 6'h20);
        dump_check(5'd11, "R10 taken forward branch");
        do_beq(5'd1, 5'd2, 16'h0040);
        do_r(5'd0, 5'd0, 5'd11, 6'h20);
        dump_check(5'd11, "R10 untaken branch continues");
        do_beq(5'd3, 5'd3, 16'hFFF0);
        dump_check(5'd3, "R10 taken backward branch");

        // R11: jumps keep the upper PC bits
        do_jump(26'h0000_600);
        dump_check(5'd4, "R11 jump target");
        do_jump(26'h0000_180);
        dump_check(5'd2, "R11 second jump target");

        // R5/R9: hold checks happen at each fetch address above; final summary
        check("R9 final PC via fetch", exp_pc[1:0], 2'b00);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule